// File: doc/BRIEF.md
# Prescaled Private Countdown Timer

This block is a 32-bit down-counter owned by a single processor. Software drives it through four word registers: a reload value, the live count, a configuration word and a sticky event flag. An 8-bit divider turns the input clock into count ticks. The counter either stops at zero (single-shot) or reloads from the reload value and keeps going (repeating). Reaching zero sets the event flag. The flag drives a level interrupt through a mask bit, and software clears it by writing a one.

Writes to the reload, count and configuration registers can start, stop or restart the counter. A group of rules for zero values decides whether such a write stops the timer quietly or lets it run to an event. Read data is registered and appears on the cycle after the read request. The interrupt output is also registered and tracks the flag and the mask.

Top module: `pct_top`

## Requirements
- R1: Byte offsets 0x00 (reload), 0x04 (count), 0x08 (config) and 0x0C (event flag) are decoded. A read of any other offset returns zero and a write to one changes nothing. Read data appears on `bus_rdata` one clock after `bus_rd`, and it shows the state before that edge.
- R2: Config bit 0 is run-enable, bit 1 selects repeating mode, bit 2 unmasks the interrupt and bits 15:8 hold the divider value. Every other config bit reads back as zero.
- R3: When the counter is running, a tick occurs every divider+1 clocks. The first tick comes divider+1 clocks after the write that started or restarted it. A config write that changes the enable bit, the mode bit or the divider restarts the divider phase.
- R4: A tick that moves the count from 1 to 0 sets the event flag. Writing 1 to bit 0 of offset 0x0C clears the flag and writing 0 leaves it set. `irq_o` is the flag ANDed with config bit 2.
- R5: A write to the reload register also sets the count. If the timer is enabled, the divider is zero and the value written is zero, the timer stops and no event is raised.
- R6: Writing zero to the count while enabled with divider zero stops a single-shot timer without an event. A repeating timer in the same case takes the reload value instead, and it stops only if that value is zero. Writing a nonzero count restarts the countdown from that value.
- R7: The counter advances only while enabled and while the divider or the newly set count is nonzero. If both are zero it stays idle.
- R8: In single-shot mode the count holds at zero after its event, and no further events occur.
- R9: In repeating mode the tick after zero reloads the count, so one period is reload+1 ticks. With reload zero and divider zero, the timer stops after its event. With reload zero and a nonzero divider, an event fires on every tick.
- R10: A config write that enables repeating mode while the count is zero loads the count from the reload value.
- R11: Reset clears the config, the event flag, the reload value, the count and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read request for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| irq_o | output | 1 | Level interrupt (event flag AND mask) |

## Verification
The table runs the counter with reload values of zero, one and several, with divider values of 0, 1, 2, 3 and 255, and in both modes. Each case is sampled either just before or just after the count reaches zero, or after several repeating periods. These cases separate a decrement from a reload, single-shot holding from repeating wraparound, and a correct tick spacing from an off-by-one in the divider. Directed cases then write zero to the reload and count registers while the timer runs, and they switch modes when the count is zero. The check of the quiet stop after a zero-reload event shows whether the block wrongly fires a second event or keeps running, and the masked and write-zero flag cases show whether the interrupt path ignores the mask bit or clears the flag on a zero write.

// File: rtl/pct_pkg.sv
package pct_pkg;
  parameter int unsigned PCT_PRE_W = 8;

  localparam int unsigned OFF_LOAD  = 0;
  localparam int unsigned OFF_COUNT = 4;
  localparam int unsigned OFF_CTRL  = 8;
  localparam int unsigned OFF_STAT  = 12;

  localparam int unsigned BIT_EN  = 0;
  localparam int unsigned BIT_PER = 1;
  localparam int unsigned BIT_IE  = 2;
  localparam int unsigned PRE_LSB = 8;

  typedef struct packed {
    logic [PCT_PRE_W-1:0] presc;
    logic                 ie;
    logic                 per;
    logic                 en;
  } cfg_t;
endpackage

// File: rtl/pct_prescaler.sv
module pct_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] presc,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q;

  assign tick = run && !restart && (phase_q == presc);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (run) begin
      if (phase_q == presc) phase_q <= '0;
      else                  phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/pct_counter.sv
module pct_counter import pct_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  cfg_t             cfg,
  input  cfg_t             cfg_new,
  input  logic             load_wr,
  input  logic             cnt_wr,
  input  logic             ctl_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] load,
  output logic             running,
  output logic             expire,
  output logic             pre_restart
);
  logic [CNT_W-1:0] cnt_q, cnt_d, load_q, load_d, nv;
  logic             run_q, run_d;
  logic             pz, pz_new;

  assign pz     = (cfg.presc == '0);
  assign pz_new = (cfg_new.presc == '0);

  always_comb begin
    cnt_d       = cnt_q;
    load_d      = load_q;
    run_d       = run_q;
    expire      = 1'b0;
    pre_restart = 1'b0;
    nv          = '0;
    if (load_wr) begin
      load_d      = wdata;
      cnt_d       = wdata;
      run_d       = cfg.en && (!pz || wdata != '0);
      pre_restart = 1'b1;
    end else if (cnt_wr) begin
      nv          = (cfg.en && cfg.per && pz && wdata == '0) ? load_q : wdata;
      cnt_d       = nv;
      run_d       = cfg.en && (!pz || nv != '0);
      pre_restart = 1'b1;
    end else if (ctl_wr) begin
      nv          = (cfg_new.en && cfg_new.per && cnt_q == '0) ? load_q : cnt_q;
      cnt_d       = nv;
      run_d       = cfg_new.en && (!pz_new || nv != '0);
      pre_restart = !run_q || (cfg_new.en != cfg.en) || (cfg_new.per != cfg.per)
                    || (cfg_new.presc != cfg.presc);
    end else if (tick) begin
      if (cnt_q > CNT_W'(1)) begin
        cnt_d = cnt_q - 1'b1;
      end else if (cnt_q == CNT_W'(1)) begin
        cnt_d  = '0;
        expire = 1'b1;
        if (!cfg.per || (load_q == '0 && pz)) run_d = 1'b0;
      end else if (cfg.per) begin
        cnt_d  = load_q;
        expire = (load_q == '0);
      end else begin
        expire = 1'b1;
        run_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      load_q <= '0;
      run_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      load_q <= load_d;
      run_q  <= run_d;
    end
  end

  assign count   = cnt_q;
  assign load    = load_q;
  assign running = run_q;
endmodule

// File: rtl/pct_top.sv
module pct_top import pct_pkg::*; #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_o
);
  localparam int PRE_W = PCT_PRE_W;

  cfg_t             cfg_q, cfg_w, cfg_d;
  logic             hit_load, hit_cnt, hit_ctl, hit_stat;
  logic             status_q, status_d, irq_q;
  logic [CNT_W-1:0] rdata_q, ctl_rd, count, load;
  logic             running, expire, pre_restart, tick;

  assign hit_load = bus_wr && (bus_addr == ADDR_W'(OFF_LOAD));
  assign hit_cnt  = bus_wr && (bus_addr == ADDR_W'(OFF_COUNT));
  assign hit_ctl  = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign hit_stat = bus_wr && (bus_addr == ADDR_W'(OFF_STAT));

  always_comb begin
    cfg_w.en    = bus_wdata[BIT_EN];
    cfg_w.per   = bus_wdata[BIT_PER];
    cfg_w.ie    = bus_wdata[BIT_IE];
    cfg_w.presc = bus_wdata[PRE_LSB +: PRE_W];
    cfg_d       = hit_ctl ? cfg_w : cfg_q;
  end

  pct_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run(running), .restart(pre_restart),
    .presc(cfg_q.presc), .tick(tick)
  );

  pct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cfg(cfg_q), .cfg_new(cfg_w),
    .load_wr(hit_load), .cnt_wr(hit_cnt), .ctl_wr(hit_ctl),
    .wdata(bus_wdata), .tick(tick), .count(count), .load(load),
    .running(running), .expire(expire), .pre_restart(pre_restart)
  );

  always_comb begin
    status_d = status_q;
    if (hit_stat && bus_wdata[0]) status_d = 1'b0;
    if (expire)                   status_d = 1'b1;
  end

  always_comb begin
    ctl_rd                     = '0;
    ctl_rd[BIT_EN]             = cfg_q.en;
    ctl_rd[BIT_PER]            = cfg_q.per;
    ctl_rd[BIT_IE]             = cfg_q.ie;
    ctl_rd[PRE_LSB +: PRE_W]   = cfg_q.presc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      status_q <= 1'b0;
      irq_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      cfg_q    <= cfg_d;
      status_q <= status_d;
      irq_q    <= status_d && cfg_d.ie;
      if (bus_rd) begin
        if (bus_addr == ADDR_W'(OFF_LOAD))       rdata_q <= load;
        else if (bus_addr == ADDR_W'(OFF_COUNT)) rdata_q <= count;
        else if (bus_addr == ADDR_W'(OFF_CTRL))  rdata_q <= ctl_rd;
        else if (bus_addr == ADDR_W'(OFF_STAT))  rdata_q <= CNT_W'(status_q);
        else                                     rdata_q <= '0;
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/pct_checker.sv
module pct_checker import pct_pkg::*; #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  bus_wdata,
  input logic              irq_o,
  input cfg_t              cfg,
  input logic              status_q,
  input logic              running,
  input logic              tick,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  load
);
  p_irq_follows_r4: assert property (@(posedge clk) disable iff (rst)
    irq_o == (status_q && cfg.ie));

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (status_q && !(bus_wr && bus_addr == ADDR_W'(OFF_STAT) && bus_wdata[0])) |=> status_q);

  p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && cfg.presc != '0) |=> !tick);

  p_zero_load_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFF_LOAD) && bus_wdata == '0 && cfg.en && cfg.presc == '0)
    |=> (!running && count == '0));

  p_run_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
    running |-> cfg.en);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!running && !bus_wr) |=> $stable(count));

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (cfg == '0 && !status_q && load == '0 && count == '0 && !irq_o));
endmodule

bind pct_top pct_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_o(irq_o), .cfg(cfg_q), .status_q(status_q),
  .running(running), .tick(tick), .count(count), .load(load)
);

// File: tb/pct_top_tb.sv
module pct_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int          n_run = 0;
  int          n_fail = 0;
  logic [31:0] d;

  always #5 clk = ~clk;

  pct_top u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [7:0]  p;
    logic        per;
    logic [15:0] ld;
    logic [15:0] n;
    logic [15:0] cnt;
    logic        irq;
  } vec_t;

  // divider, repeating, reload, idle clocks after start, expected count, expected irq
  localparam vec_t VEC [12] = '{
    '{8'd0,   1'b0, 16'd5, 16'd3,   16'd2, 1'b0},
    '{8'd0,   1'b0, 16'd5, 16'd5,   16'd0, 1'b1},
    '{8'd0,   1'b0, 16'd5, 16'd9,   16'd0, 1'b1},
    '{8'd0,   1'b1, 16'd4, 16'd6,   16'd3, 1'b1},
    '{8'd0,   1'b1, 16'd4, 16'd4,   16'd0, 1'b1},
    '{8'd2,   1'b0, 16'd5, 16'd7,   16'd3, 1'b0},
    '{8'd2,   1'b1, 16'd2, 16'd9,   16'd2, 1'b1},
    '{8'd3,   1'b1, 16'd0, 16'd8,   16'd0, 1'b1},
    '{8'd1,   1'b0, 16'd0, 16'd1,   16'd0, 1'b0},
    '{8'd0,   1'b1, 16'd0, 16'd10,  16'd0, 1'b0},
    '{8'd255, 1'b0, 16'd1, 16'd255, 16'd1, 1'b0},
    '{8'd255, 1'b0, 16'd1, 16'd256, 16'd0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] v);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk("R11 irq", 32'(irq_o), 32'h0);
    rd(5'h00, d); chk("R11 reload", d, 32'h0);
    rd(5'h04, d); chk("R11 count", d, 32'h0);
    rd(5'h08, d); chk("R11 config", d, 32'h0);
    rd(5'h0C, d); chk("R11 flag", d, 32'h0);

    // R1: unmapped offsets
    wr(5'h00, 32'd9);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h14, d); chk("R1 unmapped read", d, 32'h0);
    rd(5'h00, d); chk("R1 reload kept", d, 32'd9);
    rd(5'h08, d); chk("R1 config kept", d, 32'h0);

    // R2: config fields and reserved bits
    wr(5'h08, 32'hABCD_5A06);
    rd(5'h08, d); chk("R2 config readback", d, 32'h0000_5A06);

    // Table: R3 divider spacing, R8 single-shot, R9 repeating, R7 idle
    for (int i = 0; i < 12; i++) begin
      string tag;
      tag = (VEC[i].p == 0 && VEC[i].ld == 0) ? "R7" :
            (VEC[i].p != 0) ? "R3" : (VEC[i].per ? "R9" : "R8");
      quiesce();
      wr(5'h00, 32'(VEC[i].ld));
      wr(5'h08, {16'h0, VEC[i].p, 5'b0, 1'b1, VEC[i].per, 1'b1});
      idle(int'(VEC[i].n));
      chk($sformatf("%s irq vec%0d", tag, i), 32'(irq_o), 32'(VEC[i].irq));
      rd(5'h04, d);
      chk($sformatf("%s count vec%0d", tag, i), d, 32'(VEC[i].cnt));
    end

    // R5: zero reload while running stops quietly
    quiesce();
    wr(5'h00, 32'd100);
    wr(5'h08, 32'h5);
    idle(3);
    wr(5'h00, 32'd0);
    idle(5);
    chk("R5 irq", 32'(irq_o), 32'h0);
    rd(5'h04, d); chk("R5 count", d, 32'h0);
    rd(5'h0C, d); chk("R5 flag", d, 32'h0);

    // R6: zero count in single-shot stops quietly
    quiesce();
    wr(5'h00, 32'd100);
    wr(5'h08, 32'h5);
    idle(2);
    wr(5'h04, 32'd0);
    idle(5);
    chk("R6 oneshot irq", 32'(irq_o), 32'h0);
    rd(5'h04, d); chk("R6 oneshot count", d, 32'h0);

    // R6: zero count in repeating mode takes the reload value
    quiesce();
    wr(5'h00, 32'd10);
    wr(5'h08, 32'h7);
    idle(3);
    wr(5'h04, 32'd0);
    rd(5'h04, d); chk("R6 periodic reload", d, 32'd10);
    wr(5'h04, 32'd7);
    idle(2);
    rd(5'h04, d); chk("R6 nonzero count", d, 32'd5);

    // R9: reload zero, divider zero stops after one event
    quiesce();
    wr(5'h00, 32'd0);
    wr(5'h08, 32'h7);
    wr(5'h04, 32'd3);
    idle(6);
    chk("R9 event irq", 32'(irq_o), 32'h1);
    rd(5'h04, d); chk("R9 stopped count", d, 32'h0);
    wr(5'h0C, 32'h1);
    idle(6);
    chk("R9 no second event", 32'(irq_o), 32'h0);

    // R4: write-one-to-clear and mask
    wr(5'h04, 32'd2);
    idle(5);
    chk("R4 irq set", 32'(irq_o), 32'h1);
    wr(5'h0C, 32'h0);
    rd(5'h0C, d); chk("R4 zero write keeps flag", d, 32'h1);
    wr(5'h08, 32'h3);
    chk("R4 masked irq", 32'(irq_o), 32'h0);
    rd(5'h0C, d); chk("R4 flag while masked", d, 32'h1);
    wr(5'h0C, 32'h1);
    rd(5'h0C, d); chk("R4 flag cleared", d, 32'h0);

    // R10: switching to repeating with count zero reloads; divider restarts
    quiesce();
    wr(5'h00, 32'd6);
    wr(5'h08, 32'h1);
    idle(10);
    wr(5'h08, 32'h303);
    rd(5'h04, d); chk("R10 reload on mode switch", d, 32'd6);
    idle(6);
    rd(5'h04, d); chk("R10 divider restarted", d, 32'd5);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule